// File: doc/BRIEF.md
# Coprocessor Load/Store Handshake Sequencer

This block sits on the coprocessor side of a load/store handshake with a host pipeline. When a coprocessor load or store enters execute, the sequencer reports a two-bit handshake code every cycle. The code says whether the coprocessor is stalling, whether more transfers follow, or whether the coming data beat is the last one. The data for each beat lags its handshake cycle by one clock. So the final-beat announcement goes out one cycle ahead of the final word.

Loads write their words into an internal register bank in ascending index order from a base index. The index wraps modulo the bank size. A write lands only if the host confirmed the instruction with its pass signal during a transfer cycle, and no late cancel has arrived. Stores read the bank in the same order onto the outgoing data bus. The bus drive enable covers the whole window from the cycle after the store enters to the cycle after the next instruction enters, even when the store is cancelled or never confirmed. The sequencer runs on its own free-running clock, so it has no stall input.

Top module: `cphs_seq`

## Requirements
- R1: When no instruction is in progress, the handshake code is 2'b00 whatever busy_i does. After reset the code is 2'b00 and store_drive_o is low.
- R2: While an instruction is in progress and busy_i is high, the code is 2'b01 (WAIT), and the remaining-word count does not advance.
- R3: In each non-busy cycle of an instruction, the code is 2'b10 (GO) if two or more words remain and 2'b11 (LAST) if exactly one remains. An N-word instruction therefore shows N-1 GO cycles, then one LAST, then 2'b00. The first handshake cycle is the one after instr_valid_i is sampled.
- R4: A word count field of 0 runs as a single-word transfer: WAIT cycles while busy, then one LAST, and no GO.
- R5: Data beat k (k = 1..N) takes place in the cycle after the k-th non-WAIT handshake cycle. For a load, the beat-k value of load_data_i is written to register (base + k - 1) mod REG_N.
- R6: Load words are written only if pass_i was high in a GO or LAST cycle of the same instruction. With pass_i low throughout, the register bank is unchanged.
- R7: A late_cancel_i pulse in any cycle of an instruction blocks every load write of that instruction from that cycle onward. Beats completed earlier stay written.
- R8: During store data beat k, store_data_o carries register (base + k - 1) mod REG_N.
- R9: store_drive_o rises in the cycle after a store is sampled and stays high until the cycle after the next instruction is sampled, independent of pass_i and late_cancel_i. After a load is sampled it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running execute clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_valid_i | input | 1 | A coprocessor load/store enters execute this cycle |
| instr_is_load_i | input | 1 | 1 = load into coprocessor, 0 = store from it |
| word_cnt_i | input | CNT_W | Number of words (0 treated as 1) |
| base_idx_i | input | $clog2(REG_N) | First register index |
| busy_i | input | 1 | Coprocessor not ready this cycle |
| pass_i | input | 1 | Host confirms the instruction |
| late_cancel_i | input | 1 | Host cancels the instruction late |
| load_data_i | input | DW | Incoming load word |
| hs_code_o | output | 2 | Handshake: 00 idle, 01 WAIT, 10 GO, 11 LAST |
| store_data_o | output | DW | Outgoing store word |
| store_drive_o | output | 1 | Coprocessor owns the store data bus |

## Verification
The bench uses the default parameters: DW=32, REG_N=16 and CNT_W=4. With a 16-entry bank, a four-word transfer based at index 14 wraps through index 0. This makes the modulo ordering of R5 and R8 visible in a handful of cycles. A four-bit count lets the bench reach the largest transfer of 15 words and the zero-count case. Load effects, including those suppressed by pass or cancel, are read back through later stores at the data port.

// File: rtl/cphs_pkg.sv
package cphs_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'b00,
    HS_WAIT = 2'b01,
    HS_GO   = 2'b10,
    HS_LAST = 2'b11
  } hs_e;
endpackage

// File: rtl/cphs_count.sv
module cphs_count
  import cphs_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             busy_i,
  output hs_e              hs_o,
  output logic             step_o
);
  logic             active_q;
  logic [CNT_W-1:0] rem_q;

  assign step_o = active_q & ~busy_i;

  always_comb begin
    if (!active_q)         hs_o = HS_IDLE;
    else if (busy_i)       hs_o = HS_WAIT;
    else if (rem_q > 1)    hs_o = HS_GO;
    else                   hs_o = HS_LAST;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rem_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      rem_q    <= (cnt_i == '0) ? CNT_W'(1) : cnt_i;
    end else if (step_o) begin
      rem_q <= rem_q - 1'b1;
      if (rem_q == CNT_W'(1)) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cphs_gate.sv
module cphs_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic step_i,
  input  logic pass_i,
  input  logic cancel_i,
  output logic xfer_o,
  output logic commit_o
);
  logic xfer_q, pass_seen_q, cancel_q;

  // data beat trails its handshake cycle by one clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xfer_q      <= 1'b0;
      pass_seen_q <= 1'b0;
      cancel_q    <= 1'b0;
    end else if (start_i) begin
      xfer_q      <= 1'b0;
      pass_seen_q <= 1'b0;
      cancel_q    <= 1'b0;
    end else begin
      xfer_q <= step_i;
      if (step_i && pass_i) pass_seen_q <= 1'b1;
      if (cancel_i)         cancel_q    <= 1'b1;
    end
  end

  assign xfer_o   = xfer_q;
  assign commit_o = xfer_q & pass_seen_q & ~cancel_q & ~cancel_i;
endmodule

// File: rtl/cphs_rf.sv
module cphs_rf #(
  parameter int DW    = 32,
  parameter int REG_N = 16,
  localparam int AW   = $clog2(REG_N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [REG_N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < REG_N; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cphs_seq.sv
module cphs_seq
  import cphs_pkg::*;
#(
  parameter int DW    = 32,
  parameter int REG_N = 16,
  parameter int CNT_W = 4,
  localparam int AW   = $clog2(REG_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             instr_valid_i,
  input  logic             instr_is_load_i,
  input  logic [CNT_W-1:0] word_cnt_i,
  input  logic [AW-1:0]    base_idx_i,
  input  logic             busy_i,
  input  logic             pass_i,
  input  logic             late_cancel_i,
  input  logic [DW-1:0]    load_data_i,
  output logic [1:0]       hs_code_o,
  output logic [DW-1:0]    store_data_o,
  output logic             store_drive_o
);
  hs_e           hs;
  logic          step, xfer, commit, rf_we;
  logic [AW-1:0] ptr_q;
  logic          is_load_q, own_q;

  cphs_count #(.CNT_W(CNT_W)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(instr_valid_i),
    .cnt_i  (word_cnt_i),
    .busy_i (busy_i),
    .hs_o   (hs),
    .step_o (step)
  );

  cphs_gate u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (instr_valid_i),
    .step_i  (step),
    .pass_i  (pass_i),
    .cancel_i(late_cancel_i),
    .xfer_o  (xfer),
    .commit_o(commit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q     <= '0;
      is_load_q <= 1'b0;
      own_q     <= 1'b0;
    end else if (instr_valid_i) begin
      ptr_q     <= base_idx_i;
      is_load_q <= instr_is_load_i;
      own_q     <= ~instr_is_load_i;
    end else if (xfer) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  assign rf_we = commit & is_load_q;

  cphs_rf #(.DW(DW), .REG_N(REG_N)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (rf_we),
    .waddr_i(ptr_q),
    .wdata_i(load_data_i),
    .raddr_i(ptr_q),
    .rdata_o(store_data_o)
  );

  assign hs_code_o     = hs;
  assign store_drive_o = own_q;
endmodule

// File: rtl/cphs_seq_chk.sv
module cphs_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       instr_valid_i,
  input logic       instr_is_load_i,
  input logic       busy_i,
  input logic       late_cancel_i,
  input logic [1:0] hs_code_o,
  input logic       store_drive_o,
  input logic       rf_we
);
  AST_START_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i |=> hs_code_o != 2'b00);  // R3

  AST_BUSY_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_code_o != 2'b00 && busy_i) |-> hs_code_o == 2'b01);  // R2

  AST_LAST_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_code_o == 2'b11 && !instr_valid_i) |=> hs_code_o == 2'b00);  // R3

  AST_GO_CONTINUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_code_o == 2'b10 && !instr_valid_i) |=> hs_code_o != 2'b00);  // R3

  AST_STORE_OWNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && !instr_is_load_i) |=> store_drive_o);  // R9

  AST_OWN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |=> $stable(store_drive_o));  // R9

  AST_CANCEL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_cancel_i |-> !rf_we);  // R7
endmodule

bind cphs_seq cphs_seq_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .instr_valid_i  (instr_valid_i),
  .instr_is_load_i(instr_is_load_i),
  .busy_i         (busy_i),
  .late_cancel_i  (late_cancel_i),
  .hs_code_o      (hs_code_o),
  .store_drive_o  (store_drive_o),
  .rf_we          (rf_we)
);

// File: tb/sim_cphs_seq.sv
module sim_cphs_seq;
  localparam int DW = 32, REG_N = 16, CNT_W = 4, AW = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             instr_valid_i = 1'b0;
  logic             instr_is_load_i = 1'b0;
  logic [CNT_W-1:0] word_cnt_i = '0;
  logic [AW-1:0]    base_idx_i = '0;
  logic             busy_i = 1'b0;
  logic             pass_i = 1'b0;
  logic             late_cancel_i = 1'b0;
  logic [DW-1:0]    load_data_i = '0;
  logic [1:0]       hs_code_o;
  logic [DW-1:0]    store_data_o;
  logic             store_drive_o;

  int n_chk = 0, n_err = 0, seed = 0;
  logic [DW-1:0] exp_rf [REG_N];

  always #5 clk_i = ~clk_i;

  cphs_seq #(.DW(DW), .REG_N(REG_N), .CNT_W(CNT_W)) u0 (.*);

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  endtask

  // one instruction; canc_at < 0 means no cancel
  task automatic run_xfer(input string req, input bit ld, input int cnt, input int base,
                          input logic [15:0] bmask, input bit pas, input int canc_at);
    int  rem = (cnt == 0) ? 1 : cnt;
    bit  act = 1, dp = 0, canc = 0;
    int  ptr = base, c = 0;
    logic [1:0] exp_hs;
    @(negedge clk_i);
    instr_valid_i = 1; instr_is_load_i = ld; word_cnt_i = CNT_W'(cnt);
    base_idx_i = AW'(base); pass_i = pas; busy_i = 0; late_cancel_i = 0;
    while (act || dp) begin
      @(negedge clk_i);
      instr_valid_i = 0;
      busy_i = bmask[c % 16];
      late_cancel_i = (c == canc_at);
      exp_hs = !act ? 2'b00 : busy_i ? 2'b01 : (rem >= 2) ? 2'b10 : 2'b11;
      if (dp && ld) begin seed++; load_data_i = 32'hD00D_0000 + DW'(seed); end
      #1;
      chk(req, 32'(hs_code_o), 32'(exp_hs));
      chk("R9", 32'(store_drive_o), 32'(!ld));
      if (dp && !ld) chk({"R8 ", req}, store_data_o, exp_rf[ptr]);
      if (late_cancel_i) canc = 1;
      if (dp && ld && pas && !canc) exp_rf[ptr] = load_data_i;
      if (dp) ptr = (ptr + 1) % REG_N;
      dp = act && !busy_i;
      if (act && !busy_i) begin rem--; if (rem == 0) act = 0; end
      c++;
    end
    @(negedge clk_i);
    busy_i = 0; late_cancel_i = 0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1", 32'(hs_code_o), 32'h0);
    chk("R1", 32'(store_drive_o), 32'h0);
    busy_i = 1; #1;
    chk("R1", 32'(hs_code_o), 32'h0);
    busy_i = 0;
  endtask

  task automatic t_basic();
    run_xfer("R3", 1, 3, 2, 16'h0, 1, -1);
    run_xfer("R8", 0, 3, 2, 16'h0, 1, -1);
    run_xfer("R3", 0, 15, 1, 16'h0, 1, -1);
  endtask

  task automatic t_busy();
    run_xfer("R2", 1, 1, 5, 16'b1011, 1, -1);
    run_xfer("R2", 0, 5, 4, 16'b0001_0100, 1, -1);
  endtask

  task automatic t_zero();
    run_xfer("R4", 1, 0, 3, 16'b0001, 1, -1);
    run_xfer("R4", 0, 0, 3, 16'h0, 1, -1);
  endtask

  task automatic t_wrap();
    run_xfer("R5", 1, 4, 14, 16'h0, 1, -1);
    run_xfer("R5", 0, 4, 14, 16'b0010, 1, -1);
  endtask

  task automatic t_nopass();
    run_xfer("R6", 1, 3, 2, 16'h0, 0, -1);
    run_xfer("R6", 0, 3, 2, 16'h0, 1, -1);
  endtask

  task automatic t_cancel();
    run_xfer("R7", 1, 4, 8, 16'h0, 1, 2);
    run_xfer("R7", 0, 4, 8, 16'h0, 1, -1);
  endtask

  task automatic t_own();
    run_xfer("R9", 0, 2, 6, 16'h0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i); #1;
      chk("R9", 32'(store_drive_o), 32'h1);
      chk("R1", 32'(hs_code_o), 32'h0);
    end
    run_xfer("R9", 1, 1, 9, 16'h0, 1, -1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    for (int i = 0; i < REG_N; i++) exp_rf[i] = '0;
    #12 t_reset();
    @(negedge clk_i) rst_ni = 1'b1;
    t_reset();
    t_basic();
    t_busy();
    t_zero();
    t_wrap();
    t_nopass();
    t_cancel();
    t_own();
    report();
  end
endmodule